// File: doc/BRIEF.md
# Local L0 Trigger Emulator

This block makes level-0 trigger decisions for a detector partition, whether or not the real trigger processor is present. In global mode it passes on each trigger strobe and its 6-bit type from the external processor. In local mode it ignores that path and makes its own triggers from one of three sources:

- a downscaled count of bunch clocks;
- a 32-bit pseudo-random generator compared against a threshold;
- the rising edge of a pulser input.

Each accepted trigger gives two outputs in the same cycle: a one-clock pulse for the synchronous timing channel, and a short-broadcast request that carries the 6-bit trigger type. A busy level from the detector blocks new triggers and is forwarded to the processor. Two counters record accepted triggers and triggers that busy suppressed. Software reaches them, and the configuration, through a small register port.

Top module: `l0_trig_emu`

## Requirements
- R1: After reset both trigger outputs are low and both counters read zero.
- R2: In global mode (ctrl bit 0 = 0), when `ext_trig` is high at a clock edge and busy is low, `cha_pulse` and `chb_req` are high for the next cycle, and `chb_type` equals the `ext_type` sampled at that edge.
- R3: In local mode (ctrl bit 0 = 1), `ext_trig` has no effect on the outputs.
- R4: `busy_to_proc` equals `det_busy` in the same cycle.
- R5: A candidate trigger at an edge where `det_busy` is high produces no pulse. It increments the suppressed counter (address 5) instead.
- R6: Source 0 (ctrl bits 2:1 = 00) fires every N+1 clocks, where N is the 16-bit value at address 1.
- R7: Source 1 (ctrl bits 2:1 = 01) fires whenever the 32-bit random value is below the threshold at address 2. A threshold of 0 never fires; a threshold of all ones fires almost every clock.
- R8: Source 2 (ctrl bits 2:1 = 10) fires once per rising edge of `pulser`. A level held high fires only once. Source 3 (ctrl bits 2:1 = 11) never fires.
- R9: In local mode the broadcast type is the 6-bit value at address 3.
- R10: The accepted counter (address 4) increments once per emitted pulse.
- R11: Addresses 0 to 3 read back the value written to them. Addresses 4 and 5 are read-only counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| ext_trig | input | 1 | Trigger strobe from the external processor |
| ext_type | input | 6 | Trigger type from the external processor |
| pulser | input | 1 | External pulser level |
| det_busy | input | 1 | Busy level from the detector |
| busy_to_proc | output | 1 | Busy forwarded to the processor |
| cha_pulse | output | 1 | One-clock trigger pulse for channel A |
| chb_req | output | 1 | Short-broadcast request for channel B |
| chb_type | output | 6 | Trigger type carried by the broadcast |

## Verification
A trigger candidate sampled at a clock edge shows up on `cha_pulse`, `chb_req` and `chb_type` in the cycle after that edge. The counters change at that same edge. Forwarded busy and register reads are combinational and are due in the same cycle.

The bench drives inputs on the falling edge and samples everything on the next falling edge. It checks each pulse against a queue of expected types, or, in free-running modes, against an expected type and an expected gap between pulses.

// File: rtl/l0_trig_emu.sv
module l0_trig_emu #(
  parameter int TYPE_W = 6,
  parameter int DS_W   = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ext_trig,
  input  logic [5:0]        ext_type,
  input  logic              pulser,
  input  logic              det_busy,
  output logic              busy_to_proc,
  output logic              cha_pulse,
  output logic              chb_req,
  output logic [5:0]        chb_type
);
  logic              local_mode;
  logic [1:0]        src_sel;
  logic [DS_W-1:0]   ds_lim, ds_cnt;
  logic [31:0]       rnd_thr, lfsr;
  logic [TYPE_W-1:0] loc_type;
  logic [CNT_W-1:0]  acc_cnt, sup_cnt;
  logic              pulser_q, cand, accept, ds_hit;

  assign busy_to_proc = det_busy;
  assign ds_hit = (ds_cnt == ds_lim);

  always_comb begin
    if (!local_mode) cand = ext_trig;
    else case (src_sel)
      2'd0:    cand = ds_hit;
      2'd1:    cand = (lfsr < rnd_thr);
      2'd2:    cand = pulser & ~pulser_q;
      default: cand = 1'b0;
    endcase
  end
  assign accept = cand & ~det_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      local_mode <= 1'b0;
      src_sel    <= 2'd3;
      ds_lim     <= '0;
      rnd_thr    <= '0;
      loc_type   <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        3'd0: {src_sel, local_mode} <= cfg_wdata[2:0];
        3'd1: ds_lim   <= cfg_wdata[DS_W-1:0];
        3'd2: rnd_thr  <= cfg_wdata;
        3'd3: loc_type <= cfg_wdata[TYPE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ds_cnt   <= '0;
      lfsr     <= 32'h1;
      pulser_q <= 1'b0;
    end else begin
      pulser_q <= pulser;
      lfsr     <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (!local_mode || src_sel != 2'd0 || ds_hit) ds_cnt <= '0;
      else ds_cnt <= ds_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cha_pulse <= 1'b0;
      chb_req   <= 1'b0;
      chb_type  <= '0;
      acc_cnt   <= '0;
      sup_cnt   <= '0;
    end else begin
      cha_pulse <= accept;
      chb_req   <= accept;
      if (accept) begin
        chb_type <= local_mode ? loc_type : ext_type;
        acc_cnt  <= acc_cnt + 1'b1;
      end
      if (cand && det_busy) sup_cnt <= sup_cnt + 1'b1;
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {29'd0, src_sel, local_mode};
      3'd1:    cfg_rdata = 32'(ds_lim);
      3'd2:    cfg_rdata = rnd_thr;
      3'd3:    cfg_rdata = 32'(loc_type);
      3'd4:    cfg_rdata = 32'(acc_cnt);
      3'd5:    cfg_rdata = 32'(sup_cnt);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

module l0_trig_emu_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_busy,
  input logic             busy_to_proc,
  input logic             ext_trig,
  input logic [5:0]       ext_type,
  input logic             local_mode,
  input logic             cha_pulse,
  input logic             chb_req,
  input logic [5:0]       chb_type,
  input logic [CNT_W-1:0] acc_cnt
);
  assert_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cha_pulse == chb_req);
  assert_global_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!local_mode && ext_trig && !det_busy) |=> (cha_pulse && chb_type == $past(ext_type)));
  assert_busy_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_to_proc == det_busy);
  assert_busy_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    det_busy |=> !cha_pulse);
  assert_acc_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cha_pulse |-> acc_cnt == $past(acc_cnt) + CNT_W'(1));
endmodule

bind l0_trig_emu l0_trig_emu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .det_busy(det_busy), .busy_to_proc(busy_to_proc),
  .ext_trig(ext_trig), .ext_type(ext_type), .local_mode(local_mode),
  .cha_pulse(cha_pulse), .chb_req(chb_req), .chb_type(chb_type), .acc_cnt(acc_cnt));

// File: tb/l0_trig_emu_bench.sv
module l0_trig_emu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg_wr = 0, ext_trig = 0, pulser = 0, det_busy = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [5:0] ext_type = 0, chb_type;
  logic busy_to_proc, cha_pulse, chb_req;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [5:0] exp_q[$];
  bit auto_on = 0, last_ok = 0;
  int auto_gap = 0, last_cyc = 0, npulse = 0;
  logic [5:0] auto_type = 0;

  l0_trig_emu u_l0_trig_emu (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic ext_fire(input logic [5:0] t, input bit expect_it);
    @(negedge clk); ext_trig = 1; ext_type = t;
    if (expect_it) exp_q.push_back(t);
    @(negedge clk); ext_trig = 0;
  endtask

  // monitor: pulse at negedge after the edge that accepted it
  always @(negedge clk) if (rst_n && cha_pulse) begin
    npulse++;
    chk(chb_req, "R2 chb_req with cha_pulse", chb_req, 1);
    if (auto_on) begin
      chk(chb_type == auto_type, "R9 local type", chb_type, auto_type);
      if (auto_gap != 0 && last_ok)
        chk(cyc - last_cyc == auto_gap, "R6 downscale gap", cyc - last_cyc, auto_gap);
      last_cyc = cyc; last_ok = 1;
    end else if (exp_q.size() == 0) begin
      chk(0, "R3/R5 unexpected pulse", 1, 0);
    end else begin
      logic [5:0] e;
      e = exp_q.pop_front();
      chk(chb_type == e, "R2 broadcast type", chb_type, e);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cha_pulse && !chb_req, "R1 outputs idle", cha_pulse, 0);
    rd(3'd4, d); chk(d == 0, "R1 accepted count", d, 0);
    rd(3'd5, d); chk(d == 0, "R1 suppressed count", d, 0);

    // R2 global pass-through, including back-to-back strobes
    ext_fire(6'd5, 1); ext_fire(6'd42, 1);
    @(negedge clk); ext_trig = 1; ext_type = 6'd63; exp_q.push_back(6'd63);
    @(negedge clk); ext_type = 6'd1; exp_q.push_back(6'd1);
    @(negedge clk); ext_trig = 0;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all triggers emitted", exp_q.size(), 0);

    // R4, R5 busy
    @(negedge clk); det_busy = 1; #1;
    chk(busy_to_proc == 1, "R4 busy forwarded high", busy_to_proc, 1);
    ext_fire(6'd7, 0); ext_fire(6'd8, 0);
    @(negedge clk); det_busy = 0; #1;
    chk(busy_to_proc == 0, "R4 busy forwarded low", busy_to_proc, 0);
    repeat (2) @(negedge clk);
    rd(3'd5, d); chk(d == 2, "R5 suppressed count", d, 2);
    rd(3'd4, d); chk(d == 4, "R10 accepted count", d, 4);

    // R11 register readback
    wr(3'd1, 32'd3); rd(3'd1, d); chk(d == 3, "R11 downscale readback", d, 3);
    wr(3'd3, 32'd17); rd(3'd3, d); chk(d == 17, "R11 type readback", d, 17);
    wr(3'd2, 32'h1234_5678); rd(3'd2, d); chk(d == 32'h1234_5678, "R11 threshold readback", d, 32'h1234_5678);

    // R6 downscale with ext_trig ignored (R3)
    auto_on = 1; auto_type = 6'd17; auto_gap = 4; last_ok = 0; npulse = 0;
    wr(3'd0, 32'b001);
    rd(3'd0, d); chk(d == 1, "R11 ctrl readback", d, 1);
    repeat (8) ext_fire(6'd2, 0);
    repeat (24) @(negedge clk);
    chk(npulse >= 9 && npulse <= 11, "R6 R3 downscale count", npulse, 10);

    // R5 busy in local mode: 20 edges of N=3 give exactly 5 candidates
    rd(3'd5, s0);
    @(negedge clk); det_busy = 1; npulse = 0;
    repeat (20) @(negedge clk);
    det_busy = 0; last_ok = 0;
    chk(npulse <= 1, "R5 no pulse while busy", npulse, 0);
    rd(3'd5, d); chk(d - s0 == 5, "R5 suppressed delta", d - s0, 5);
    wr(3'd0, 32'b111); repeat (2) @(negedge clk);

    // R7 random
    auto_gap = 0; auto_type = 6'd9; wr(3'd3, 32'd9);
    wr(3'd2, 32'd0); wr(3'd0, 32'b011); npulse = 0;
    repeat (100) @(negedge clk);
    chk(npulse == 0, "R7 zero threshold", npulse, 0);
    wr(3'd2, 32'hFFFF_FFFF); npulse = 0;
    repeat (100) @(negedge clk);
    chk(npulse >= 95, "R7 full threshold", npulse, 100);
    wr(3'd0, 32'b111); repeat (2) @(negedge clk);

    // R8 pulser edges and source 3 idle
    npulse = 0; auto_type = 6'd33; wr(3'd3, 32'd33); wr(3'd0, 32'b101);
    @(negedge clk); pulser = 1;
    repeat (10) @(negedge clk);
    chk(npulse == 1, "R8 held level fires once", npulse, 1);
    pulser = 0; repeat (3) @(negedge clk);
    pulser = 1; @(negedge clk); pulser = 0; repeat (3) @(negedge clk);
    chk(npulse == 2, "R8 second edge fires", npulse, 2);
    wr(3'd0, 32'b111); npulse = 0;
    pulser = 1; @(negedge clk); pulser = 0; repeat (3) @(negedge clk);
    chk(npulse == 0, "R8 source 3 idle", npulse, 0);

    auto_on = 0;
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule